// File: doc/BRIEF.md
# Sprite Table Copy DMA Engine

This block sequences a fixed-length copy of a sprite attribute table. A byte written to its control register selects a source page, and the engine then produces one address pair per transfer. The source address is the chosen page with an ascending offset. The destination address places that same offset in a fixed high page. A one-clock strobe marks each pair, and an active flag marks the copy window. The block moves no data and does no arbitration against the CPU. A separate memory path consumes the address pairs, and the active flag can be used to lock the CPU out of the source and destination memories.

Time in the engine advances only on clocks where the machine-cycle enable is high. After a write there is a short startup delay. Transfers then follow at a fixed stride, and the engine ends a fixed number of ticks after the write. Reading the control register returns the page that was loaded. When no copy is pending or running, the read returns an all-ones sentinel.

Top module: `spr_dma`

## Requirements
- R1: A write to the register address (default 0xFF46) stores the written byte as the source page (source address = byte << 8). Until the copy ends, a read returns that byte.
- R2: A read returns 0xFF when no page is stored: after reset, and after a copy has ended.
- R3: A write to any other address changes neither the readback nor the outputs, and starts no copy.
- R4: The first strobe appears after the 4th enabled tick that follows the write. `active` stays low before that tick.
- R5: A copy makes exactly 160 strobes, one every 4 enabled ticks. Their source addresses are page:0x00 through page:0x9F, in ascending order.
- R6: Every strobe carries a destination address of 0xFE00 OR'd with the low byte of its source address.
- R7: On the 644th enabled tick after the write, the engine returns to idle with no strobe, `active` falls, and the stored page is dropped.
- R8: `active` is high for exactly the 640 clocks from the first strobe up to the end tick, and it is high during every strobe.
- R9: A write during the delay or during the copy restarts the whole sequence from the new page, with the tick count at zero. A write wins over an enabled tick in the same clock.
- R10: While the enable is low, the tick count, state and outputs do not advance.
- R11: A synchronous reset leaves the engine idle, with no strobe, `active` low and a readback of 0xFF.
- R12: Each strobe lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Machine-cycle enable; the engine advances only when high |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data (source page) |
| bus_rdata | output | 8 | Register readback: stored page, or 0xFF |
| src_addr | output | 16 | Source address of the current transfer |
| dst_addr | output | 16 | Destination address of the current transfer |
| xfer_stb | output | 1 | One-clock transfer strobe |
| active | output | 1 | High while the copy window is open |

## Verification
The bench builds the engine with its default parameters: register address 0xFF46, a 4-tick startup delay, a stride of 4, 160 bytes and destination page 0xFE. These values put the full 644-tick sequence within a short run, so every vector checks the exact first-strobe tick, the strobe count, the end tick and the 640-clock active window. Because the copy is short, the bench can also restart the engine both inside the startup delay and in the middle of a copy, and reset it mid-copy. It freezes the enable for a stretch to show that ticks, not clocks, set the schedule.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_COPY = 2'd2
  } dma_state_e;
endpackage

// File: rtl/spr_dma_regs.sv
module spr_dma_regs #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFF46,
  parameter logic [7:0] EMPTY_VAL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              clear,
  output logic              start,
  output logic [7:0]        page,
  output logic              page_vld,
  output logic [7:0]        rdata
);
  logic       hit;
  logic [7:0] page_q;
  logic       vld_q;

  assign hit   = (bus_addr == REG_ADDR);
  assign start = bus_wr && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      vld_q  <= 1'b0;
    end else if (start) begin
      page_q <= bus_wdata;
      vld_q  <= 1'b1;
    end else if (clear) begin
      vld_q  <= 1'b0;
    end
  end

  assign page     = page_q;
  assign page_vld = vld_q;
  assign rdata    = vld_q ? page_q : EMPTY_VAL;

  // R1: a decoded write stores the byte and marks it valid
  a_r1_load: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_ADDR) |=> (page_vld && page == $past(bus_wdata)));

  // R3: with no decoded write, the stored page is untouched
  a_r3_no_write_no_change: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == REG_ADDR) |=> $stable(page));

  // R7: the end of a copy drops the stored page
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clear && !(bus_wr && bus_addr == REG_ADDR)) |=> !page_vld);
endmodule

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
  import spr_dma_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int START_DLY = 4,
  parameter int STRIDE    = 4,
  parameter int NBYTES    = 160
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       start,
  output logic       fire,
  output logic [7:0] offset,
  output logic       done,
  output logic       copying
);
  localparam int END_CNT = START_DLY + STRIDE * NBYTES;
  localparam int PH_W    = (STRIDE > 1) ? $clog2(STRIDE) : 1;

  dma_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic [PH_W-1:0]  ph_q;
  logic [PH_W-1:0]  ph_nx;
  logic [7:0]       off_q;
  logic             at_first;
  logic             at_end;

  assign cnt_nx   = cnt_q + 1'b1;
  assign ph_nx    = (ph_q == PH_W'(STRIDE - 1)) ? '0 : ph_q + 1'b1;
  assign at_first = (cnt_nx == CNT_W'(START_DLY));
  assign at_end   = (cnt_nx == CNT_W'(END_CNT));

  always_comb begin
    fire = 1'b0;
    done = 1'b0;
    if (!start && tick_en) begin
      if (state_q == ST_WAIT && at_first) begin
        fire = 1'b1;
      end else if (state_q == ST_COPY) begin
        if (at_end) done = 1'b1;
        else if (ph_nx == '0) fire = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ph_q    <= '0;
      off_q   <= '0;
    end else if (start) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      ph_q    <= '0;
      off_q   <= '0;
    end else if (tick_en) begin
      case (state_q)
        ST_WAIT: begin
          cnt_q <= cnt_nx;
          if (at_first) begin
            state_q <= ST_COPY;
            ph_q    <= '0;
          end
        end
        ST_COPY: begin
          if (at_end) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_nx;
            ph_q  <= ph_nx;
          end
        end
        default: ;
      endcase
      if (fire) off_q <= off_q + 1'b1;
    end
  end

  assign offset  = off_q;
  assign copying = (state_q == ST_COPY);

  // R4: the startup delay never overruns its limit
  a_r4_wait_bound: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) |-> (cnt_q < CNT_W'(START_DLY)));

  // R9: a write restarts the sequence with a cleared count
  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    start |=> (state_q == ST_WAIT && cnt_q == '0 && off_q == '0));

  // R10: with the enable low and no write, the count holds
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !start) |=> ($stable(cnt_q) && $stable(state_q)));

  // R7: the end tick lands in idle
  a_r7_end_idle: assert property (@(posedge clk) disable iff (rst)
    done |=> (state_q == ST_IDLE));

  // R5: no transfer beyond the table length
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    fire |-> (off_q < 8'(NBYTES)));
endmodule

// File: rtl/spr_dma_addr.sv
module spr_dma_addr #(
  parameter logic [7:0] DST_PAGE = 8'hFE,
  parameter int         STRIDE   = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fire,
  input  logic [7:0]  page,
  input  logic [7:0]  offset,
  input  logic        copying,
  output logic [15:0] src_addr,
  output logic [15:0] dst_addr,
  output logic        stb
);
  logic [15:0] src_q;
  logic [15:0] dst_q;
  logic        stb_q;
  logic [15:0] src_nx;

  assign src_nx = {page, offset};

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      dst_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= fire;
      if (fire) begin
        src_q <= src_nx;
        dst_q <= {DST_PAGE, 8'h00} | {8'h00, src_nx[7:0]};
      end
    end
  end

  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign stb      = stb_q;

  // R12: a strobe never lasts two clocks
  a_r12_single: assert property (@(posedge clk) disable iff (rst || STRIDE < 2)
    stb_q |=> !stb_q);

  // R8: every strobe falls inside the copy window
  a_r8_stb_in_window: assert property (@(posedge clk) disable iff (rst)
    stb_q |-> copying);

  // R6: the destination low byte tracks the source low byte
  a_r6_dst_follows: assert property (@(posedge clk) disable iff (rst)
    stb_q |-> (dst_q[7:0] == src_q[7:0] && dst_q[15:8] == DST_PAGE));
endmodule

// File: rtl/spr_dma.sv
module spr_dma #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] REG_ADDR  = 16'hFF46,
  parameter logic [7:0]  DST_PAGE  = 8'hFE,
  parameter int          START_DLY = 4,
  parameter int          STRIDE    = 4,
  parameter int          NBYTES    = 160,
  parameter int          CNT_W     = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_en,
  input  logic [15:0] bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic [15:0] src_addr,
  output logic [15:0] dst_addr,
  output logic        xfer_stb,
  output logic        active
);
  logic       start;
  logic       fire;
  logic       done;
  logic       copying;
  logic [7:0] page;
  logic       page_vld;
  logic [7:0] offset;

  spr_dma_regs #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .EMPTY_VAL(8'hFF)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .clear    (done),
    .start    (start),
    .page     (page),
    .page_vld (page_vld),
    .rdata    (bus_rdata)
  );

  spr_dma_seq #(
    .CNT_W    (CNT_W),
    .START_DLY(START_DLY),
    .STRIDE   (STRIDE),
    .NBYTES   (NBYTES)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .tick_en(tick_en),
    .start  (start),
    .fire   (fire),
    .offset (offset),
    .done   (done),
    .copying(copying)
  );

  spr_dma_addr #(
    .DST_PAGE(DST_PAGE),
    .STRIDE  (STRIDE)
  ) u_addr (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .page    (page),
    .offset  (offset),
    .copying (copying),
    .src_addr(src_addr),
    .dst_addr(dst_addr),
    .stb     (xfer_stb)
  );

  assign active = copying;

  // R11/R2: while idle with no page, the readback is the sentinel
  a_r2_sentinel: assert property (@(posedge clk) disable iff (rst)
    !page_vld |-> (bus_rdata == 8'hFF && !active));

  // R7: the copy window closes with the page dropped
  a_r7_window_close: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> (!page_vld || $past(start)));
endmodule

// File: tb/spr_dma_bench.sv
`timescale 1ns/1ps
module spr_dma_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] src_addr;
  logic [15:0] dst_addr;
  logic        xfer_stb;
  logic        active;

  always #10 clk = ~clk;

  spr_dma u_spr_dma (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_addr(src_addr), .dst_addr(dst_addr),
    .xfer_stb(xfer_stb), .active(active)
  );

  int checks = 0;
  int fails  = 0;
  bit reported = 0;

  // page, expected first source, expected last source
  localparam logic [39:0] VEC [4] = '{
    {8'hC0, 16'hC000, 16'hC09F},
    {8'h00, 16'h0000, 16'h009F},
    {8'hFF, 16'hFF00, 16'hFF9F},
    {8'h81, 16'h8100, 16'h819F}
  };

  int first_k, n_stb, n_act, end_k, bad, dbl, rd_bad;
  logic [15:0] first_src, last_src;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic observe(input logic [7:0] pg, input int lim);
    bit prev = 0;
    first_k = -1; n_stb = 0; n_act = 0; end_k = -1; bad = 0; dbl = 0; rd_bad = 0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (xfer_stb) begin
        if (first_k < 0) begin first_k = k; first_src = src_addr; end
        if (src_addr !== {pg, 8'(n_stb)} || dst_addr !== ({8'hFE, 8'h00} | {8'h00, src_addr[7:0]}) || !active)
          bad++;
        last_src = src_addr;
        n_stb++;
      end
      if (xfer_stb && prev) dbl++;
      prev = xfer_stb;
      if (active) n_act++;
      if (end_k < 0 && first_k > 0 && !active) end_k = k;
      if (end_k < 0 && bus_rdata !== pg) rd_bad++;
      if (first_k < 0 && active) bad++;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(!active, "R11 active after reset", active, 0);
    chk(!xfer_stb, "R11 strobe after reset", xfer_stb, 0);
    chk(bus_rdata == 8'hFF, "R11/R2 readback after reset", bus_rdata, 8'hFF);

    tick_en = 1'b1;
    // R3: write to a neighbour address is ignored
    reg_write(16'hFF47, 8'h12);
    observe(8'hFF, 12);
    chk(n_stb == 0 && n_act == 0, "R3 no copy from other address", n_stb + n_act, 0);
    chk(bus_rdata == 8'hFF, "R3 readback unchanged", bus_rdata, 8'hFF);

    // vector table: full copies
    foreach (VEC[i]) begin
      logic [7:0] pg;
      pg = VEC[i][39:32];
      reg_write(16'hFF46, pg);
      observe(pg, 700);
      chk(rd_bad == 0, "R1 readback holds page", rd_bad, 0);
      chk(first_k == 4, "R4 first strobe tick", first_k, 4);
      chk(first_src == VEC[i][31:16], "R5 first source", first_src, VEC[i][31:16]);
      chk(last_src == VEC[i][15:0], "R5 last source", last_src, VEC[i][15:0]);
      chk(n_stb == 160, "R5 strobe count", n_stb, 160);
      chk(bad == 0, "R6 address pairs and ordering", bad, 0);
      chk(n_act == 640, "R8 active window", n_act, 640);
      chk(end_k == 644, "R7 end tick", end_k, 644);
      chk(dbl == 0, "R12 one-clock strobe", dbl, 0);
      chk(bus_rdata == 8'hFF, "R2 readback after end", bus_rdata, 8'hFF);
    end

    // R9: restart during the copy
    reg_write(16'hFF46, 8'h30);
    observe(8'h30, 50);
    chk(n_stb == 12, "R9 strobes before restart", n_stb, 12);
    reg_write(16'hFF46, 8'h50);
    observe(8'h50, 700);
    chk(first_k == 4 && first_src == 16'h5000, "R9 restart mid-copy first", first_src, 16'h5000);
    chk(n_stb == 160 && end_k == 644, "R9 restart mid-copy full run", n_stb, 160);

    // R9: restart during the startup delay
    reg_write(16'hFF46, 8'h11);
    observe(8'h11, 2);
    reg_write(16'hFF46, 8'h22);
    observe(8'h22, 700);
    chk(first_k == 4, "R9 restart in delay clears count", first_k, 4);
    chk(bad == 0 && n_stb == 160, "R9 restart in delay new page", bad, 0);

    // R10: enable low freezes the engine
    tick_en = 1'b0;
    reg_write(16'hFF46, 8'h70);
    observe(8'h70, 20);
    chk(n_stb == 0 && n_act == 0, "R10 frozen without enable", n_stb + n_act, 0);
    chk(bus_rdata == 8'h70, "R10/R1 readback while frozen", bus_rdata, 8'h70);
    tick_en = 1'b1;
    observe(8'h70, 700);
    chk(first_k == 4 && end_k == 644, "R10 resumes on enable", first_k, 4);

    // R11: reset mid-copy
    reg_write(16'hFF46, 8'h40);
    observe(8'h40, 100);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!active && !xfer_stb, "R11 reset mid-copy idle", active, 0);
    chk(bus_rdata == 8'hFF, "R11 reset mid-copy readback", bus_rdata, 8'hFF);
    observe(8'hFF, 20);
    chk(n_stb == 0, "R11 no strobes after reset", n_stb, 0);

    summary();
  end
endmodule